// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block collects 64 level-sensitive interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. Each source has a pending bit, an enable bit, a type bit (normal or fast) and a 4-bit priority. A 5-bit threshold decides which normal sources are allowed to raise the normal request. Software sees the state through a 32-bit word-addressed register port. A single `addr` serves both the read and the write strobe. Read data is combinational from the current state. Register updates, including the clearing side effect of a vector read, take place at the next rising clock edge.

A source input is sampled every cycle. When its level differs from the level seen in the previous cycle, the new level is copied into its pending bit. Between changes, the pending bit holds its value, so force writes and acknowledges persist. Enables are changed one at a time by writing a source number, or 32 at a time through bulk words. Software services interrupts by reading a vector word. The read returns the chosen source and clears its pending bit in the same access.

Reset is asynchronous and active-low. Its release is synchronised inside the block, so the block stays in reset for two rising edges after `rst_n` goes high.

Top module: `vic_regbank`

## Requirements
- R1: After reset the pending, enable, type, control and all priority state is zero, the threshold reads 0x1f, and both request outputs are low.
- R2: A write to word 2 sets the enable bit of the source numbered by `wdata[5:0]`, and a write to word 3 clears that bit. Other enable bits are unchanged, and both words read as zero.
- R3: Words 4 and 5 hold the enable bits of sources 63..32 and 31..0 (bit n of the word is source 32+n or n). Words 6 and 7 hold the type bits in the same layout, where 1 means fast. All four can be read back.
- R4: Word 8+j holds the priorities of sources 8(7-j) to 8(7-j)+7. Source 8k+n sits at bits 4n+3:4n of its word. Priority words read back what was written.
- R5: A write to word 1 stores only `wdata[4:0]` as the threshold, and reads return it zero-extended.
- R6: A write to word 0 stores only bits 24 and 22..18 of the data. The abort-flag position, bit 25, is never stored and always reads 0.
- R7: When a source input changes level, its pending bit takes the new level at the next edge. Words 18 and 19 read pending bits 63..32 and 31..0.
- R8: A write to word 20 or 21 replaces pending bits 63..32 or 31..0 with the data, overriding a source change in the same cycle. Both words read as zero.
- R9: Words 22/23 read pending AND enabled AND normal-type, and words 24/25 read pending AND enabled AND fast-type, each as a high/low half.
- R10: The fast request is high exactly when some source is pending, enabled and of fast type.
- R11: The normal request is high when some source is pending, enabled and of normal type and either the threshold is 0x1f or the highest such priority is strictly greater than the threshold. Otherwise it is low.
- R12: A read of word 16 returns {source number in bits 31:16, priority in bits 15:0}. It picks the highest-priority pending, enabled, normal source, and the highest number wins a tie. The read clears that pending bit, and the clear beats a rise of that source in the same cycle. With no candidate the read returns 0xFFFFFFFF.
- R13: A read of word 17 returns the lowest-numbered pending, enabled, fast source and clears its pending bit. With no candidate it returns 0xFFFFFFFF.
- R14: Writes to words 16..19 and 22..25 and to the vector window (words 0x40..0xBF) change nothing. A read of word 0x40 returns 4, and any other unmapped word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt source levels, one bit per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers acknowledge on vector words) |
| addr | input | 10 | Word address shared by read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| norm_irq_o | output | 1 | Normal interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check several properties on every cycle:
- enable-by-number writes take effect at the next edge;
- the threshold keeps five bits;
- an acknowledged source has its pending bit low one cycle later;
- writes to read-only words or the vector window leave all state untouched;
- the chosen normal and fast sources are genuine candidates, and the fast one is the lowest numbered.

Some behaviour only the bench scenarios can show, so the bench runs directed cases alongside randomised traffic:
- the priority-word mapping;
- tie-breaking toward the higher source number;
- the precedence of an acknowledge over a same-cycle source rise, and of a force over a source change;
- how the threshold gates the normal request for thresholds at, below and above the winning priority.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 10;
  localparam int unsigned NSRC = 64;
  localparam int unsigned PW   = 4;
  localparam int unsigned MW   = 5;

  // word indices of the register map
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_MASK   = 1;
  localparam int unsigned W_ENSET  = 2;
  localparam int unsigned W_ENCLR  = 3;
  localparam int unsigned W_ENHI   = 4;
  localparam int unsigned W_ENLO   = 5;
  localparam int unsigned W_TYHI   = 6;
  localparam int unsigned W_TYLO   = 7;
  localparam int unsigned W_PRIO0  = 8;
  localparam int unsigned W_PRIO7  = 15;
  localparam int unsigned W_NVEC   = 16;
  localparam int unsigned W_FVEC   = 17;
  localparam int unsigned W_SRCHI  = 18;
  localparam int unsigned W_SRCLO  = 19;
  localparam int unsigned W_FRCHI  = 20;
  localparam int unsigned W_FRCLO  = 21;
  localparam int unsigned W_NPHI   = 22;
  localparam int unsigned W_NPLO   = 23;
  localparam int unsigned W_FPHI   = 24;
  localparam int unsigned W_FPLO   = 25;
  localparam int unsigned W_VWIN_LO = 'h40;
  localparam int unsigned W_VWIN_HI = 'hBF;

  localparam logic [DW-1:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [DW-1:0] VEC0_WORD = 32'd4;
endpackage

// File: rtl/vic_rst_sync.sv
`timescale 1ns/1ps
module vic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/vic_state.sv
`timescale 1ns/1ps
module vic_state import vic_pkg::*; #(
  parameter int unsigned N     = NSRC,
  parameter int unsigned PBITS = PW,
  parameter int unsigned MBITS = MW,
  parameter int unsigned D     = DW,
  parameter int unsigned A     = AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         src_i,
  input  logic                 wr_en,
  input  logic [A-1:0]         waddr,
  input  logic [D-1:0]         wdata,
  input  logic                 ack_en,
  input  logic [$clog2(N)-1:0] ack_idx,
  output logic [N-1:0]         pend_o,
  output logic [N-1:0]         en_o,
  output logic [N-1:0]         type_o,
  output logic [N*PBITS-1:0]   prio_o,
  output logic [MBITS-1:0]     mask_o,
  output logic [D-1:0]         ctrl_o
);
  localparam int unsigned H      = N / 2;
  localparam int unsigned IDXB   = $clog2(N);
  localparam int unsigned PPW    = D / PBITS;
  localparam int unsigned PWORDS = N / PPW;
  localparam int unsigned PWB    = $clog2(PWORDS);

  logic [N-1:0]     src_q;
  logic [N-1:0]     pend_q, pend_n;
  logic [N-1:0]     en_q, en_n;
  logic [N-1:0]     type_q, type_n;
  logic [D-1:0]     prio_q [PWORDS];
  logic [D-1:0]     prio_n [PWORDS];
  logic [MBITS-1:0] mask_q;
  logic [D-1:0]     ctrl_q;

  logic [N-1:0]   evt;
  logic           in_win, wr_ok;
  logic           ctrl_we, mask_we, en_we, type_we, prio_we;
  logic           frc_hi, frc_lo, pend_we;
  logic [PWB-1:0] prio_slot;
  logic           ro_hit;

  // ---------------- write decode ----------------
  assign in_win  = (waddr >= A'(W_VWIN_LO)) && (waddr <= A'(W_VWIN_HI));
  assign wr_ok   = wr_en && !in_win;
  assign ctrl_we = wr_ok && (waddr == A'(W_CTRL));
  assign mask_we = wr_ok && (waddr == A'(W_MASK));
  assign en_we   = wr_ok && (waddr >= A'(W_ENSET)) && (waddr <= A'(W_ENLO));
  assign type_we = wr_ok && ((waddr == A'(W_TYHI)) || (waddr == A'(W_TYLO)));
  assign prio_we = wr_ok && (waddr >= A'(W_PRIO0)) && (waddr <= A'(W_PRIO7));
  assign frc_hi  = wr_ok && (waddr == A'(W_FRCHI));
  assign frc_lo  = wr_ok && (waddr == A'(W_FRCLO));
  // first priority word sits on a PWORDS-aligned index: last-minus-offset is the inverse
  assign prio_slot = ~waddr[PWB-1:0];
  assign ro_hit  = wr_en && (((waddr >= A'(W_NVEC)) && (waddr <= A'(W_SRCLO))) ||
                             ((waddr >= A'(W_NPHI)) && (waddr <= A'(W_FPLO))));

  // a source is sampled as an event only when its level moved
  assign evt     = src_i ^ src_q;
  assign pend_we = (|evt) || frc_hi || frc_lo || ack_en;

  // ---------------- next state ----------------
  always_comb begin
    pend_n = pend_q;
    for (int i = 0; i < N; i++) begin
      if (evt[i]) pend_n[i] = src_i[i];
    end
    if (frc_hi) pend_n[N-1:H] = wdata[H-1:0];
    if (frc_lo) pend_n[H-1:0] = wdata[H-1:0];
    // acknowledge has the final word
    if (ack_en) pend_n[ack_idx] = 1'b0;
  end

  always_comb begin
    en_n = en_q;
    if (waddr == A'(W_ENSET)) en_n[wdata[IDXB-1:0]] = 1'b1;
    else if (waddr == A'(W_ENCLR)) en_n[wdata[IDXB-1:0]] = 1'b0;
    else if (waddr == A'(W_ENHI)) en_n[N-1:H] = wdata[H-1:0];
    else if (waddr == A'(W_ENLO)) en_n[H-1:0] = wdata[H-1:0];
  end

  always_comb begin
    type_n = type_q;
    if (waddr == A'(W_TYHI)) type_n[N-1:H] = wdata[H-1:0];
    else type_n[H-1:0] = wdata[H-1:0];
  end

  always_comb begin
    for (int k = 0; k < PWORDS; k++) prio_n[k] = prio_q[k];
    prio_n[prio_slot] = wdata;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
      type_q <= '0;
      mask_q <= '1;
      ctrl_q <= '0;
      for (int k = 0; k < PWORDS; k++) prio_q[k] <= '0;
    end else begin
      src_q <= src_i;
      if (pend_we) pend_q <= pend_n;
      if (en_we)   en_q   <= en_n;
      if (type_we) type_q <= type_n;
      if (mask_we) mask_q <= wdata[MBITS-1:0];
      if (ctrl_we) ctrl_q <= wdata & CTRL_KEEP;
      if (prio_we) begin
        for (int k = 0; k < PWORDS; k++) prio_q[k] <= prio_n[k];
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign type_o = type_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;

  for (genvar k = 0; k < PWORDS; k++) begin : g_prio_flat
    assign prio_o[k*D +: D] = prio_q[k];
  end

  // ---------------- assertions ----------------
  // R2
  enset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && waddr == A'(W_ENSET)) |=> en_q[$past(wdata[IDXB-1:0])]);
  // R2
  enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && waddr == A'(W_ENCLR)) |=> !en_q[$past(wdata[IDXB-1:0])]);
  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata[MBITS-1:0])));
  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> !pend_q[$past(ack_idx)]);
  // R14
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_hit && !ack_en && (evt == '0)) |=>
      ($stable(pend_q) && $stable(en_q) && $stable(type_q) && $stable(mask_q)));
  // R14
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win && !ack_en && (evt == '0)) |=>
      ($stable(pend_q) && $stable(en_q) && $stable(type_q) && $stable(mask_q) && $stable(ctrl_q)));
endmodule

// File: rtl/vic_norm_pick.sv
`timescale 1ns/1ps
module vic_norm_pick import vic_pkg::*; #(
  parameter int unsigned N     = NSRC,
  parameter int unsigned PBITS = PW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         flags,
  input  logic [N*PBITS-1:0]   prio,
  output logic                 valid,
  output logic [$clog2(N)-1:0] idx,
  output logic [PBITS-1:0]     best
);
  localparam int unsigned IDXB = $clog2(N);

  // ascending scan with >= lets the higher index win a tie
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (flags[i] && (!valid || (prio[i*PBITS +: PBITS] >= best))) begin
        valid = 1'b1;
        idx   = IDXB'(i);
        best  = prio[i*PBITS +: PBITS];
      end
    end
  end

  // R12
  npick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> flags[idx]);
  // R12
  npick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (flags == '0));
endmodule

// File: rtl/vic_fast_pick.sv
`timescale 1ns/1ps
module vic_fast_pick import vic_pkg::*; #(
  parameter int unsigned N = NSRC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         flags,
  output logic                 valid,
  output logic [$clog2(N)-1:0] idx
);
  localparam int unsigned IDXB = $clog2(N);

  // descending scan leaves the lowest set index
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags[i]) idx = IDXB'(i);
    end
  end
  assign valid = |flags;

  // R13
  fpick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (flags[idx] && ((flags & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/vic_regbank.sv
`timescale 1ns/1ps
module vic_regbank import vic_pkg::*; #(
  parameter int unsigned N     = NSRC,
  parameter int unsigned PBITS = PW,
  parameter int unsigned MBITS = MW,
  parameter int unsigned D     = DW,
  parameter int unsigned A     = AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [A-1:0]  addr,
  input  logic [D-1:0]  wdata,
  output logic [D-1:0]  rdata,
  output logic          norm_irq_o,
  output logic          fast_irq_o
);
  localparam int unsigned H      = N / 2;
  localparam int unsigned IDXB   = $clog2(N);
  localparam int unsigned HALFW  = D / 2;
  localparam int unsigned PPW    = D / PBITS;
  localparam int unsigned PWORDS = N / PPW;
  localparam int unsigned PWB    = $clog2(PWORDS);

  logic                 rst_q_n;
  logic [N-1:0]         pend, en, typ;
  logic [N*PBITS-1:0]   prio_flat;
  logic [MBITS-1:0]     mask;
  logic [D-1:0]         ctrl;
  logic [N-1:0]         nflags, fflags;
  logic                 nvalid, fvalid;
  logic [IDXB-1:0]      nidx, fidx;
  logic [PBITS-1:0]     nprio;
  logic                 rd_nvec, rd_fvec;
  logic                 ack_en;
  logic [IDXB-1:0]      ack_idx;
  logic [PWB-1:0]       rd_slot;

  vic_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  vic_state #(.N(N), .PBITS(PBITS), .MBITS(MBITS), .D(D), .A(A)) i_state (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .src_i   (src_i),
    .wr_en   (wr_en),
    .waddr   (addr),
    .wdata   (wdata),
    .ack_en  (ack_en),
    .ack_idx (ack_idx),
    .pend_o  (pend),
    .en_o    (en),
    .type_o  (typ),
    .prio_o  (prio_flat),
    .mask_o  (mask),
    .ctrl_o  (ctrl)
  );

  assign nflags = pend & en & ~typ;
  assign fflags = pend & en & typ;

  vic_norm_pick #(.N(N), .PBITS(PBITS)) i_norm_pick (
    .clk   (clk),
    .rst_n (rst_q_n),
    .flags (nflags),
    .prio  (prio_flat),
    .valid (nvalid),
    .idx   (nidx),
    .best  (nprio)
  );

  vic_fast_pick #(.N(N)) i_fast_pick (
    .clk   (clk),
    .rst_n (rst_q_n),
    .flags (fflags),
    .valid (fvalid),
    .idx   (fidx)
  );

  // ---------------- acknowledge on vector reads ----------------
  assign rd_nvec = rd_en && (addr == A'(W_NVEC));
  assign rd_fvec = rd_en && (addr == A'(W_FVEC));
  assign ack_en  = (rd_nvec && nvalid) || (rd_fvec && fvalid);
  assign ack_idx = rd_nvec ? nidx : fidx;

  // ---------------- read mux ----------------
  assign rd_slot = ~addr[PWB-1:0];

  always_comb begin
    rdata = '0;
    if (addr == A'(W_CTRL))       rdata = ctrl;
    else if (addr == A'(W_MASK))  rdata = D'(mask);
    else if (addr == A'(W_ENHI))  rdata = D'(en[N-1:H]);
    else if (addr == A'(W_ENLO))  rdata = D'(en[H-1:0]);
    else if (addr == A'(W_TYHI))  rdata = D'(typ[N-1:H]);
    else if (addr == A'(W_TYLO))  rdata = D'(typ[H-1:0]);
    else if ((addr >= A'(W_PRIO0)) && (addr <= A'(W_PRIO7)))
      rdata = prio_flat[int'(rd_slot)*D +: D];
    else if (addr == A'(W_NVEC))
      rdata = nvalid ? {HALFW'(nidx), HALFW'(nprio)} : '1;
    else if (addr == A'(W_FVEC))
      rdata = fvalid ? D'(fidx) : '1;
    else if (addr == A'(W_SRCHI)) rdata = D'(pend[N-1:H]);
    else if (addr == A'(W_SRCLO)) rdata = D'(pend[H-1:0]);
    else if (addr == A'(W_NPHI))  rdata = D'(nflags[N-1:H]);
    else if (addr == A'(W_NPLO))  rdata = D'(nflags[H-1:0]);
    else if (addr == A'(W_FPHI))  rdata = D'(fflags[N-1:H]);
    else if (addr == A'(W_FPLO))  rdata = D'(fflags[H-1:0]);
    else if (addr == A'(W_VWIN_LO)) rdata = VEC0_WORD;
  end

  // ---------------- request outputs ----------------
  assign fast_irq_o = |fflags;
  assign norm_irq_o = nvalid && ((mask == '1) || (MBITS'(nprio) > mask));

  // R10
  fast_match_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    fast_irq_o == fvalid);
  // R11
  norm_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    norm_irq_o |-> nvalid);
  // R11
  norm_top_prio_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (nvalid && (nprio == '1) && (mask < MBITS'(15))) |-> norm_irq_o);
endmodule

// File: tb/test_vic_regbank.sv
`timescale 1ns/1ps
module test_vic_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_i;
  logic        wr_en, rd_en;
  logic [9:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        norm_irq_o, fast_irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // model state
  logic [63:0] m_pend, m_en, m_type, m_srcq, cur_src;
  logic [31:0] m_prio [8];
  logic [4:0]  m_mask;
  logic [31:0] m_ctrl;

  vic_regbank i_vic_regbank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .norm_irq_o(norm_irq_o), .fast_irq_o(fast_irq_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_p(int i);
    return m_prio[i/8][4*(i%8) +: 4];
  endfunction

  function automatic int m_nbest();
    int b = -1;
    logic [63:0] f = m_pend & m_en & ~m_type;
    for (int i = 0; i < 64; i++)
      if (f[i] && (b < 0 || m_p(i) >= m_p(b))) b = i;
    return b;
  endfunction

  function automatic int m_fbest();
    logic [63:0] f = m_pend & m_en & m_type;
    for (int i = 0; i < 64; i++) if (f[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_norm_out();
    int b = m_nbest();
    if (b < 0) return 0;
    if (m_mask == 5'h1f) return 1;
    return ({1'b0, m_p(b)} > m_mask) ? 1 : 0;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    logic [63:0] nf = m_pend & m_en & ~m_type;
    logic [63:0] ff = m_pend & m_en & m_type;
    int b;
    case (a)
      0: return m_ctrl;
      1: return {27'd0, m_mask};
      4: return m_en[63:32];
      5: return m_en[31:0];
      6: return m_type[63:32];
      7: return m_type[31:0];
      8, 9, 10, 11, 12, 13, 14, 15: return m_prio[15 - a];
      16: begin b = m_nbest(); return (b < 0) ? 32'hFFFF_FFFF : {16'(b), 12'd0, m_p(b)}; end
      17: begin b = m_fbest(); return (b < 0) ? 32'hFFFF_FFFF : 32'(b); end
      18: return m_pend[63:32];
      19: return m_pend[31:0];
      22: return nf[63:32];
      23: return nf[31:0];
      24: return ff[63:32];
      25: return ff[31:0];
      'h40: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R6";
      1: return "R5";
      2, 3: return "R2";
      4, 5, 6, 7: return "R3";
      8, 9, 10, 11, 12, 13, 14, 15: return "R4";
      16: return "R12";
      17: return "R13";
      18, 19: return "R7";
      20, 21: return "R8";
      22, 23, 24, 25: return "R9";
      default: return "R14";
    endcase
  endfunction

  // one clock cycle: drive, check against model, advance model to the edge
  task automatic step(input bit w, input bit r, input int a, input logic [31:0] d,
                      input logic [63:0] s, input string tag);
    int ack;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 10'(a); wdata = d; src_i = s;
    #1;
    chk({31'd0, norm_irq_o}, m_norm_out(), "R11");
    chk({31'd0, fast_irq_o}, (m_fbest() >= 0) ? 32'd1 : 32'd0, "R10");
    if (r) chk(rdata, exp_read(a), tag);
    ack = -1;
    if (r && a == 16) ack = m_nbest();
    if (r && a == 17) ack = m_fbest();
    for (int i = 0; i < 64; i++) if (s[i] != m_srcq[i]) m_pend[i] = s[i];
    m_srcq = s;
    if (w) begin
      case (a)
        0: m_ctrl = d & 32'h017C_0000;
        1: m_mask = d[4:0];
        2: m_en[d[5:0]] = 1'b1;
        3: m_en[d[5:0]] = 1'b0;
        4: m_en[63:32] = d;
        5: m_en[31:0] = d;
        6: m_type[63:32] = d;
        7: m_type[31:0] = d;
        8, 9, 10, 11, 12, 13, 14, 15: m_prio[15 - a] = d;
        20: m_pend[63:32] = d;
        21: m_pend[31:0] = d;
        default: ;
      endcase
    end
    if (ack >= 0) m_pend[ack] = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, cur_src, tag_of(a));
  endtask
  task automatic rd(input int a);
    step(1'b0, 1'b1, a, 32'd0, cur_src, tag_of(a));
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 0, 32'd0, cur_src, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_i = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    cur_src = '0; m_pend = '0; m_en = '0; m_type = '0; m_srcq = '0;
    m_mask = 5'h1f; m_ctrl = '0;
    for (int k = 0; k < 8; k++) m_prio[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk({30'd0, norm_irq_o, fast_irq_o}, 32'd0, "R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) idle();

    // R1 reset state
    for (int a = 0; a < 26; a++) rd(a);
    rd(1);
    chk(rdata, 32'h1f, "R1");

    // R6 control keeps only defined bits
    wr(0, 32'hFFFF_FFFF); rd(0);
    chk(rdata, 32'h017C_0000, "R6");
    // R5 threshold width
    wr(1, 32'hFFFF_FFE3); rd(1);
    chk(rdata, 32'h3, "R5");
    wr(1, 32'h1f);

    // R2 enable by number
    wr(2, 32'h7F); wr(2, 32'h40);
    rd(4); chk(rdata, 32'h8000_0000, "R2");
    rd(5); chk(rdata, 32'h1, "R2");
    wr(3, 32'hC0); rd(5); chk(rdata, 32'h0, "R2");
    rd(2); chk(rdata, 0, "R2");

    // R4 priority mapping, R7 source capture, R12 tie and ack
    wr(15, 32'h0000_00A0); wr(14, 32'h0000_00A0);
    wr(2, 1); wr(2, 9);
    cur_src[1] = 1'b1; cur_src[9] = 1'b1;
    idle();
    rd(19); chk(rdata, 32'h0000_0202, "R7");
    rd(23); chk(rdata, 32'h0000_0202, "R9");
    chk({31'd0, norm_irq_o}, 1, "R11");
    rd(16); chk(rdata, 32'h0009_000A, "R12");
    rd(16); chk(rdata, 32'h0001_000A, "R12");
    rd(16); chk(rdata, 32'hFFFF_FFFF, "R12");
    rd(19); chk(rdata, 32'h0, "R7");

    // R11 threshold gating
    wr(21, 32'h2);
    wr(1, 5);    idle(); chk({31'd0, norm_irq_o}, 1, "R11");
    wr(1, 10);   idle(); chk({31'd0, norm_irq_o}, 0, "R11");
    wr(1, 9);    idle(); chk({31'd0, norm_irq_o}, 1, "R11");
    wr(1, 16);   idle(); chk({31'd0, norm_irq_o}, 0, "R11");
    wr(1, 5'h1f); idle(); chk({31'd0, norm_irq_o}, 1, "R11");

    // R10 / R13 fast path
    wr(7, 32'h2); idle();
    chk({31'd0, fast_irq_o}, 1, "R10");
    chk({31'd0, norm_irq_o}, 0, "R11");
    rd(25); chk(rdata, 32'h2, "R9");
    wr(21, 32'h202); wr(7, 32'h202);
    rd(17); chk(rdata, 32'd1, "R13");
    rd(17); chk(rdata, 32'd9, "R13");
    rd(17); chk(rdata, 32'hFFFF_FFFF, "R13");
    idle(); chk({31'd0, fast_irq_o}, 0, "R10");

    // R12 acknowledge beats a same-cycle source rise
    wr(7, 32'h0);
    cur_src[1] = 1'b0; idle();
    wr(21, 32'h2);
    cur_src[1] = 1'b1;
    step(1'b0, 1'b1, 16, 32'd0, cur_src, "R12");
    chk(rdata, 32'h0001_000A, "R12");
    rd(19); chk(rdata, 32'h0, "R12");

    // R8 force beats a same-cycle source change
    cur_src[2] = 1'b1;
    step(1'b1, 1'b0, 21, 32'h0, cur_src, "R8");
    rd(19); chk(rdata, 32'h0, "R8");
    rd(20); chk(rdata, 32'h0, "R8");
    wr(20, 32'h8000_0000);
    rd(18); chk(rdata, 32'h8000_0000, "R8");

    // R14 ignored writes and fixed words
    wr(18, 32'hFFFF_FFFF); wr(22, 32'hFFFF_FFFF); wr(16, 32'hFFFF_FFFF);
    rd(18); chk(rdata, 32'h8000_0000, "R14");
    wr('h44, 32'hFFFF_FFFF); wr('h40, 32'h0);
    rd(1); chk(rdata, 32'h1f, "R14");
    rd('h40); chk(rdata, 32'd4, "R14");
    rd('h3FF); chk(rdata, 32'd0, "R14");
    rd('h44); chk(rdata, 32'd0, "R14");

    // randomised traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 16);
      int a = int'($urandom % 26);
      logic [31:0] d = $urandom;
      if ($urandom % 16 == 0) a = (($urandom % 2) == 0) ? 'h40 + int'($urandom % 'h80) : 'h3F0;
      if ($urandom % 4 == 0) cur_src[$urandom % 64] ^= 1'b1;
      if (a == 1 && ($urandom % 2) == 0) d = 32'h1f;
      step(r < 6, (r >= 6) && (r < 13), a, d, cur_src, tag_of(a));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule